// File: doc/BRIEF.md
# Per-Channel Conversion Calibration Engine

This block sits behind the decimation filter of a multi-channel sigma-delta converter. Each channel owns a signed offset coefficient and an unsigned gain coefficient. Every filter word that arrives on the input stream is corrected before it leaves on the output stream: the channel's offset is taken away first, and the difference is then scaled by the channel's gain. The gain is a fixed-point value in which the mid code `2^(GW-1)` means a factor of exactly one. The product is rounded to nearest, with halves rounded upward, and clamped to the signed output range.

A command port starts one of four calibration kinds. Zero-scale and full-scale calibration each come in two kinds. The internal kinds use a reference source inside the converter, and the system kinds use whatever is applied to the input pins. While a calibration is pending, the next filter word is not corrected. It is written straight into the offset register (zero-scale) or the gain register (full-scale) of the channel tagged on that word. The block then drops back to idle and raises its ready flag. Two plain status outputs serve the analog side and the filter. One steers the input multiplexer to an internal zero or full-scale source. The other forces the filter to its slowest rate during a calibration when chopping is on.

Both streams use valid/ready. An input word is taken on any edge where `in_valid` and `in_ready` are both high. A word held on the output keeps its data and channel until `out_ready` is seen high. In idle mode, `in_ready` is low only while an output word is held and `out_ready` is low. During a calibration, `in_ready` stays high because the captured word produces no output.

Top module: `cal_engine`

## Requirements
- R1: After reset, every offset register is 0, the gain register of channel c holds `2^(GW-1) + c*GAIN_TRIM`, `mode_q` is idle (3'b000), `rdy` is 1 and `out_valid` is 0.
- R2: A word accepted in idle mode leaves as `sat(floor(((raw - off) * gain + 2^(GW-2)) / 2^(GW-1)))`. Here raw and off are signed two's complement and gain is unsigned. `sat` clamps to [-2^(OW-1), 2^(OW-1)-1].
- R3: The corrected word appears with `out_valid` high on the edge that accepts the input word, and `out_chan` carries the input word's `in_chan`.
- R4: In idle mode, `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_chan` hold steady.
- R5: The command codes on `cmd_mode` are 3'b100 internal zero-scale, 3'b101 internal full-scale, 3'b110 system zero-scale and 3'b111 system full-scale. Bit 0 selects full-scale and bit 1 selects system. A command with `cmd_valid` high is taken only in idle mode and becomes `mode_q` on the next edge. Codes with bit 2 clear, and any command given while a calibration is pending, change nothing.
- R6: A zero-scale calibration writes the captured word into the offset register of that word's channel only. A full-scale calibration writes the word's bit pattern, as an unsigned value, into that channel's gain register only.
- R7: While a calibration is pending, `rdy` is 0, `in_ready` is 1 and no new output word is produced. On the edge that captures a word, `mode_q` returns to idle and `rdy` rises.
- R8: `src_sel` is 2'b01 during an internal zero-scale calibration, 2'b10 during an internal full-scale calibration, and 2'b00 otherwise.
- R9: `rate_sel` equals `SLOW_RATE` while a calibration is pending and `chop_en` is 1. Otherwise it follows `rate_word`.
- R10: When a command is taken on the same edge that accepts an input word, that word is corrected as a normal conversion with the old coefficients. The calibration captures the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Filter word valid |
| in_ready | output | 1 | Engine can take a filter word |
| in_data | input | DW | Raw signed filter word |
| in_chan | input | CW | Channel of the filter word |
| cmd_valid | input | 1 | Calibration command strobe |
| cmd_mode | input | 3 | Calibration command code |
| chop_en | input | 1 | Chopping enabled |
| rate_word | input | RW | Normal filter rate setting |
| out_valid | output | 1 | Corrected word valid |
| out_ready | input | 1 | Downstream takes the corrected word |
| out_data | output | OW | Corrected signed word |
| out_chan | output | CW | Channel of the corrected word |
| rdy | output | 1 | No calibration pending |
| mode_q | output | 3 | Current mode (3'b000 idle) |
| src_sel | output | 2 | Input source steering for the analog side |
| rate_sel | output | RW | Rate the filter should run at |

## Verification
Two functions can coincide on one edge. A calibration command can be taken on the same edge that accepts a filter word, and a capture can occur while an earlier corrected word is still held by back-pressure. The bench provokes the first case by driving `cmd_valid` and `in_valid` in the same cycle. It provokes the second by letting a pseudo-random `out_ready` pattern run during calibrations. A behavioural model then decides, on every cycle, which word was corrected and which was stored. Its predicted outputs and stream flags are compared with the design on every clock.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'b000,
    MODE_ZS_INT = 3'b100,
    MODE_FS_INT = 3'b101,
    MODE_ZS_SYS = 3'b110,
    MODE_FS_SYS = 3'b111
  } cal_mode_e;

  typedef enum logic [1:0] {
    SRC_PINS = 2'b00,
    SRC_ZERO = 2'b01,
    SRC_FULL = 2'b10
  } src_sel_e;

endpackage

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
  parameter int unsigned CH        = 8,
  parameter int unsigned DW        = 24,
  parameter int unsigned GW        = 24,
  parameter int unsigned GAIN_TRIM = 3,
  localparam int unsigned CW       = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rd_chan,
  output logic [DW-1:0] rd_off,
  output logic [GW-1:0] rd_gain,
  input  logic          wr_en,
  input  logic          wr_full,
  input  logic [CW-1:0] wr_chan,
  input  logic [DW-1:0] wr_word
);

  logic [DW-1:0] off_all  [CH];
  logic [GW-1:0] gain_all [CH];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    localparam logic [63:0] PRESET64 = (64'd1 << (GW - 1)) + 64'(c) * 64'(GAIN_TRIM);
    localparam logic [GW-1:0] PRESET = PRESET64[GW-1:0];

    logic [DW-1:0] off_r;
    logic [GW-1:0] gain_r;
    logic          hit;

    assign hit = wr_en && (wr_chan == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_r  <= '0;
        gain_r <= PRESET;
      end else if (hit) begin
        if (wr_full) gain_r <= GW'(wr_word);
        else         off_r  <= wr_word;
      end
    end

    assign off_all[c]  = off_r;
    assign gain_all[c] = gain_r;
  end

  assign rd_off  = off_all[rd_chan];
  assign rd_gain = gain_all[rd_chan];

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int unsigned RW              = 8,
  parameter logic [RW-1:0] SLOW_RATE     = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_mode,
  input  logic          capture,
  input  logic          chop_en,
  input  logic [RW-1:0] rate_word,
  output cal_mode_e     mode,
  output logic          busy,
  output logic [1:0]    src_sel,
  output logic [RW-1:0] rate_sel
);

  cal_mode_e mode_r, mode_n;

  always_comb begin
    mode_n = mode_r;
    if (mode_r != MODE_IDLE) begin
      if (capture) mode_n = MODE_IDLE;
    end else if (cmd_valid && cmd_mode[2]) begin
      mode_n = cal_mode_e'(cmd_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= MODE_IDLE;
    else        mode_r <= mode_n;
  end

  assign mode = mode_r;
  assign busy = (mode_r != MODE_IDLE);

  always_comb begin
    unique case (mode_r)
      MODE_ZS_INT: src_sel = SRC_ZERO;
      MODE_FS_INT: src_sel = SRC_FULL;
      default:     src_sel = SRC_PINS;
    endcase
  end

  assign rate_sel = (busy && chop_en) ? SLOW_RATE : rate_word;

endmodule

// File: rtl/cal_corr_path.sv
module cal_corr_path #(
  parameter int unsigned CH = 8,
  parameter int unsigned DW = 24,
  parameter int unsigned GW = 24,
  parameter int unsigned OW = 24,
  localparam int unsigned CW = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] raw,
  input  logic [CW-1:0] chan,
  input  logic [DW-1:0] off,
  input  logic [GW-1:0] gain,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [OW-1:0] out_data,
  output logic [CW-1:0] out_chan
);

  localparam int unsigned PW = DW + GW + 2;
  localparam logic [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (GW - 2);
  localparam logic [PW-1:0] MAXV = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic [PW-1:0] MINV = {{(PW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [DW:0]   diff;
  logic signed [PW-1:0] a_ext, b_ext, prod, rnd, scaled;
  logic [OW-1:0]        clamped;

  assign diff   = $signed({raw[DW-1], raw}) - $signed({off[DW-1], off});
  assign a_ext  = $signed({{(GW+1){diff[DW]}}, diff});
  assign b_ext  = $signed({{(DW+2){1'b0}}, gain});
  assign prod   = a_ext * b_ext;
  assign rnd    = prod + $signed(HALF);
  assign scaled = rnd >>> (GW - 1);

  always_comb begin
    if (scaled > $signed(MAXV))      clamped = MAXV[OW-1:0];
    else if (scaled < $signed(MINV)) clamped = MINV[OW-1:0];
    else                             clamped = scaled[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= clamped;
      out_chan  <= chan;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cal_engine.sv
module cal_engine
  import cal_pkg::*;
#(
  parameter int unsigned CH          = 8,
  parameter int unsigned DW          = 24,
  parameter int unsigned GW          = 24,
  parameter int unsigned OW          = 24,
  parameter int unsigned RW          = 8,
  parameter int unsigned GAIN_TRIM   = 3,
  parameter logic [RW-1:0] SLOW_RATE = '1,
  localparam int unsigned CW         = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_chan,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_mode,
  input  logic          chop_en,
  input  logic [RW-1:0] rate_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic [CW-1:0] out_chan,
  output logic          rdy,
  output logic [2:0]    mode_q,
  output logic [1:0]    src_sel,
  output logic [RW-1:0] rate_sel
);

  cal_mode_e     mode;
  logic          busy, accept, capture, load;
  logic [DW-1:0] cur_off;
  logic [GW-1:0] cur_gain;

  assign in_ready = busy || !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign capture  = accept && busy;
  assign load     = accept && !busy;

  cal_ctrl #(.RW(RW), .SLOW_RATE(SLOW_RATE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .capture(capture), .chop_en(chop_en), .rate_word(rate_word),
    .mode(mode), .busy(busy), .src_sel(src_sel), .rate_sel(rate_sel)
  );

  cal_coef_bank #(.CH(CH), .DW(DW), .GW(GW), .GAIN_TRIM(GAIN_TRIM)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_chan(in_chan), .rd_off(cur_off), .rd_gain(cur_gain),
    .wr_en(capture), .wr_full(mode[0]), .wr_chan(in_chan), .wr_word(in_data)
  );

  cal_corr_path #(.CH(CH), .DW(DW), .GW(GW), .OW(OW)) u_path (
    .clk(clk), .rst_n(rst_n),
    .load(load), .raw(in_data), .chan(in_chan),
    .off(cur_off), .gain(cur_gain),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_chan(out_chan)
  );

  assign rdy    = !busy;
  assign mode_q = mode;

endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk #(
  parameter int unsigned OW          = 24,
  parameter int unsigned CW          = 3,
  parameter int unsigned RW          = 8,
  parameter logic [RW-1:0] SLOW_RATE = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          chop_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic [CW-1:0] out_chan,
  input logic          rdy,
  input logic [2:0]    mode_q,
  input logic [1:0]    src_sel,
  input logic [RW-1:0] rate_sel
);

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_q == 3'b000) |=> out_valid);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  a_r7_open: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b000) |-> (in_ready && !rdy));

  a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b000 && (!out_valid || out_ready)) |=> !out_valid);

  a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b000 && in_valid && in_ready) |=> (rdy && mode_q == 3'b000));

  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b000 && !in_valid) |=> $stable(mode_q));

  a_r8_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000 || mode_q[1]) |-> (src_sel == 2'b00));

  a_r9_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b000 && chop_en) |-> (rate_sel == SLOW_RATE));

endmodule

bind cal_engine cal_engine_chk #(
  .OW(OW), .CW(CW), .RW(RW), .SLOW_RATE(SLOW_RATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .chop_en(chop_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_chan(out_chan), .rdy(rdy), .mode_q(mode_q),
  .src_sel(src_sel), .rate_sel(rate_sel)
);

// File: tb/sim_cal_engine.sv
`timescale 1ns/1ps
module sim_cal_engine;

  localparam int CH = 8, DW = 24, CW = 3, RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_chan = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_mode = 3'b000;
  logic chop_en = 1'b0;
  logic [RW-1:0] rate_word = 8'h23;
  logic out_valid, out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_chan;
  logic rdy;
  logic [2:0] mode_q;
  logic [1:0] src_sel;
  logic [RW-1:0] rate_sel;

  always #10 clk = ~clk;

  cal_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .cmd_valid(cmd_valid),
    .cmd_mode(cmd_mode), .chop_en(chop_en), .rate_word(rate_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .rdy(rdy), .mode_q(mode_q), .src_sel(src_sel),
    .rate_sel(rate_sel)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string ctx = "reset";

  longint m_off [CH];
  longint m_gain[CH];
  int     m_mode;
  bit     m_ov;
  longint m_od;
  int     m_oc;

  task automatic chk(bit ok, string req, longint act, longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s): actual %0d expected %0d at %0t", req, ctx, act, exp_v, $time);
    end
  endtask

  function automatic longint corr(longint raw, longint off, longint g);
    longint p;
    p = (raw - off) * g + (longint'(1) <<< 22);
    p = p >>> 23;
    if (p > 64'sd8388607)  p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < CH; c++) begin
        m_off[c]  = 0;
        m_gain[c] = 64'h800000 + c * 3;
      end
      m_mode = 0; m_ov = 0; m_od = 0; m_oc = 0;
    end else begin
      int  old_mode;
      bit  rd, acc;
      old_mode = m_mode;
      rd  = (old_mode != 0) || !m_ov || out_ready;
      acc = in_valid && rd;
      if (old_mode == 0 && acc) begin
        m_ov = 1;
        m_od = corr(longint'($signed(in_data)), m_off[in_chan], m_gain[in_chan]);
        m_oc = int'(in_chan);
      end else if (out_ready) begin
        m_ov = 0;
      end
      if (old_mode != 0 && acc) begin
        if (old_mode[0]) m_gain[in_chan] = longint'(in_data);
        else             m_off[in_chan]  = longint'($signed(in_data));
        m_mode = 0;
      end else if (old_mode == 0 && cmd_valid && cmd_mode[2]) begin
        m_mode = int'(cmd_mode);
      end
    end
  end

  // Comparison one nanosecond before each rising edge.
  always @(negedge clk) begin
    #9;
    if (rst_n && !done) begin
      bit  e_rdy;
      int  e_src;
      e_rdy = (m_mode == 0);
      e_src = (m_mode == 4) ? 1 : (m_mode == 5) ? 2 : 0;
      chk(out_valid == m_ov, "R3", out_valid, m_ov);
      if (m_ov && out_valid) begin
        chk(longint'($signed(out_data)) == m_od, "R2", longint'($signed(out_data)), m_od);
        chk(int'(out_chan) == m_oc, "R3", out_chan, m_oc);
      end
      chk(in_ready == ((m_mode != 0) || !m_ov || out_ready), "R4", in_ready,
          (m_mode != 0) || !m_ov || out_ready);
      chk(rdy == e_rdy, "R7", rdy, e_rdy);
      chk(int'(mode_q) == m_mode, "R5", mode_q, m_mode);
      chk(int'(src_sel) == e_src, "R8", src_sel, e_src);
      chk(rate_sel == ((m_mode != 0 && chop_en) ? 8'hFF : rate_word), "R9", rate_sel,
          (m_mode != 0 && chop_en) ? 8'hFF : rate_word);
    end
  end

  // Pseudo-random back-pressure when enabled.
  bit bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  task automatic send(int ch, logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_chan = CW'(ch); in_data = d;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic command(logic [2:0] m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_mode = 3'b000;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    ctx = "R1 reset state";
    chk(rdy == 1'b1, "R1", rdy, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(mode_q == 3'b000, "R1", mode_q, 0);
    rst_n = 1'b1;

    ctx = "R1 presets through R2 correction";
    send(0, 24'h001000);
    send(3, -24'sd74565);
    send(6, 24'h000800);
    ctx = "R2 saturation high and low";
    send(7, 24'h7FFFFF);
    send(7, 24'h800000);

    ctx = "R6 system zero-scale on channel 2";
    command(3'b110);
    send(2, 24'h000100);
    ctx = "R5 reserved code ignored";
    command(3'b011);
    repeat (2) @(negedge clk);
    ctx = "R6 internal full-scale on channel 2";
    command(3'b101);
    send(2, 24'h400000);
    send(2, 24'h000300);
    send(1, 24'h000300);
    ctx = "R8 internal zero-scale on channel 5";
    command(3'b100);
    send(5, 24'hFFFF00);
    send(5, 24'h7FFFFF);
    ctx = "R9 chop on, system full-scale with busy command ignored R5";
    chop_en = 1'b1;
    command(3'b111);
    command(3'b100);
    repeat (2) @(negedge clk);
    send(1, 24'h600000);
    send(1, 24'h100000);
    chop_en = 1'b0;

    ctx = "R10 command and word on one edge";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 3'b100;
    in_valid = 1'b1; in_chan = 3'd4; in_data = 24'h000050;
    @(negedge clk);
    cmd_valid = 1'b0; in_valid = 1'b0;
    send(4, 24'h000020);
    send(4, 24'h000070);

    ctx = "R4 back-pressure with calibrations";
    bp_en = 1'b1;
    seed = 12345;
    for (int i = 0; i < 60; i++) begin
      seed = seed * 1103515245 + 12345;
      if (i % 15 == 7) command(3'(4 + (i % 4)));
      send((seed >>> 8) & 7, DW'(seed >>> 4));
    end
    bp_en = 1'b0;
    repeat (5) @(negedge clk);
    finish_up();
  end

endmodule